// File: doc/BRIEF.md
# Quadrant-Rotation Frequency Detector

This block is the frequency-acquisition half of a clock and data recovery loop that runs without a reference clock. The recovered clock is available in two phases, in-phase and quadrature, a quarter period apart. Each data transition, rising or falling, samples both phases. The two samples form a two-bit quadrant code. The way this code moves from one transition to the next shows whether the recovered clock runs fast or slow against the data rate. The block compares each new code with the one held from the previous transition and issues a one-cycle up or down request that steers the oscillator.

In this synchronous form, an upstream stage delivers a transition strobe together with the in-phase and quadrature levels it captured at that transition. The detector gives a trustworthy direction only while the oscillator is within about a quarter of the data rate. Beyond half the data rate its indication reverses. An enable input lets the surrounding loop silence the detector once phase lock is reached and hand control to the phase loop. The stored code keeps following the strobes while the detector is silenced, so enabling it again gives correct results at once.

Top module: `qrot_freq_det`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `up_pls` and `dn_pls` are low.
- R2: The first strobe after reset only loads the quadrant code and produces no pulse, whatever the code was before reset.
- R3: The quadrant code is {`i_smp`, `q_smp`} (in-phase bit is the MSB). When a strobed code of 2'b01 follows a held code of 2'b00, `dn_pls` is high in the cycle after the strobe.
- R4: When a strobed code of 2'b00 follows a held code of 2'b10, `up_pls` is high in the cycle after the strobe.
- R5: Every other pair of held and strobed codes produces no pulse, and this includes an unchanged code.
- R6: Without a strobe, the sample inputs are ignored and the held code is kept. No pulse is issued in the cycle after a cycle with no strobe.
- R7: While `fd_en` is low, both outputs are low in the following cycle. Strobes still update the held code.
- R8: `up_pls` and `dn_pls` are never high together, and each pulse is one cycle long for each qualifying strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_stb | input | 1 | High for one cycle for each data transition |
| i_smp | input | 1 | In-phase clock level captured at the transition |
| q_smp | input | 1 | Quadrature clock level captured at the transition |
| fd_en | input | 1 | Enables the up/down outputs |
| up_pls | output | 1 | Request to raise the oscillator frequency |
| dn_pls | output | 1 | Request to lower the oscillator frequency |

## Verification
The hardest case to reach is proof that the held code really survives. This covers stretches with no strobe, stretches with the outputs disabled, and a reset that falls between two codes. None of these shows on the outputs while it is happening. The stimulus first loads 2'b10 under one of these conditions, then strobes 2'b00 with the outputs enabled. An up pulse, or its required absence after reset, is the only visible evidence. The bench also sweeps all sixteen code pairs and sends back-to-back strobes so that up and down pulses sit in adjacent cycles.

// File: rtl/qrot_freq_det.sv
module qrot_freq_det (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_stb,
  input  logic i_smp,
  input  logic q_smp,
  input  logic fd_en,
  output logic up_pls,
  output logic dn_pls
);

  logic [1:0] quad_q;
  logic       armed_q;
  logic [1:0] quad_new;
  logic       slow_hit;
  logic       fast_hit;

  assign quad_new = {i_smp, q_smp};
  assign slow_hit = edge_stb && armed_q && (quad_q == 2'b10) && (quad_new == 2'b00);
  assign fast_hit = edge_stb && armed_q && (quad_q == 2'b00) && (quad_new == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q  <= 2'b00;
      armed_q <= 1'b0;
    end else if (edge_stb) begin
      quad_q  <= quad_new;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_pls <= 1'b0;
      dn_pls <= 1'b0;
    end else begin
      up_pls <= fd_en && slow_hit;
      dn_pls <= fd_en && fast_hit;
    end
  end

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(up_pls && dn_pls));

  // R6
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_stb |=> (!up_pls && !dn_pls));

  // R7
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fd_en |=> (!up_pls && !dn_pls));

  // R2
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && !armed_q) |=> (!up_pls && !dn_pls));

  // R3
  dn_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && fd_en && armed_q && quad_q == 2'b00 && i_smp == 1'b0 && q_smp == 1'b1) |=> dn_pls);

  // R4
  up_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && fd_en && armed_q && quad_q == 2'b10 && i_smp == 1'b0 && q_smp == 1'b0) |=> up_pls);

endmodule

// File: tb/qrot_freq_det_tb.sv
module qrot_freq_det_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edge_stb = 1'b0, i_smp = 1'b0, q_smp = 1'b0, fd_en = 1'b1;
  logic up_pls, dn_pls;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic up; logic dn; string tag; } exp_t;
  exp_t exp_q[$];

  logic [1:0] m_code = 2'b00;
  logic       m_armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrot_freq_det u_dut (
    .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .i_smp(i_smp),
    .q_smp(q_smp), .fd_en(fd_en), .up_pls(up_pls), .dn_pls(dn_pls)
  );

  task automatic check(input logic au, input logic ad, input logic eu, input logic ed, input string tag);
    n_chk++;
    if (au !== eu || ad !== ed) begin
      n_bad++;
      $display("FAIL %s: up/dn=%b%b expected %b%b at %0t", tag, au, ad, eu, ed, $time);
    end
  endtask

  task automatic step(input logic s, input logic [1:0] c, input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    edge_stb = s; {i_smp, q_smp} = c; fd_en = en;
    e.up = s && m_armed && en && m_code == 2'b10 && c == 2'b00;
    e.dn = s && m_armed && en && m_code == 2'b00 && c == 2'b01;
    e.tag = tag;
    exp_q.push_back(e);
    if (s) begin m_code = c; m_armed = 1'b1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; edge_stb = 1'b0;
    #1 check(up_pls, dn_pls, 1'b0, 1'b0, "R1");
    @(negedge clk);
    check(up_pls, dn_pls, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    m_code = 2'b00; m_armed = 1'b0;
    @(posedge clk); #1 check(up_pls, dn_pls, 1'b0, 1'b0, "R1");
  endtask

  always begin
    @(posedge clk); #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(up_pls, dn_pls, e.up, e.dn, e.tag);
      if (up_pls && dn_pls) check(1'b1, 1'b1, 1'b0, 1'b0, "R8");
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R2: first strobe 01 over reset value 00 must not pulse
    step(1, 2'b01, 1, "R2");
    step(1, 2'b00, 1, "R5");
    step(1, 2'b01, 1, "R3");
    step(1, 2'b11, 1, "R5");
    step(1, 2'b10, 1, "R5");
    step(1, 2'b00, 1, "R4");
    step(1, 2'b00, 1, "R5");
    // sweep all pairs; R3 / R4 / R5
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        step(1, a[1:0], 1, "R5");
        step(1, b[1:0], 1, (a == 0 && b == 1) ? "R3" : (a == 2 && b == 0) ? "R4" : "R5");
        step(0, 2'b00, 1, "R6");
      end
    // R6: inputs move without strobe, held 10 survives
    step(1, 2'b10, 1, "R5");
    step(0, 2'b01, 1, "R6");
    step(0, 2'b11, 1, "R6");
    step(0, 2'b00, 1, "R6");
    step(1, 2'b00, 1, "R6");
    // R7: disabled output, code keeps updating
    step(1, 2'b00, 0, "R7");
    step(1, 2'b01, 0, "R7");
    step(1, 2'b10, 0, "R7");
    step(1, 2'b00, 1, "R7");
    // R8: adjacent up then down
    step(1, 2'b10, 1, "R8");
    step(1, 2'b00, 1, "R8");
    step(1, 2'b01, 1, "R8");
    step(0, 2'b01, 1, "R8");
    // R2: reset between 10 and 00
    step(1, 2'b10, 1, "R5");
    step(0, 2'b10, 1, "R6");
    @(posedge clk); #1;
    do_reset();
    step(1, 2'b00, 1, "R2");
    step(1, 2'b01, 1, "R3");
    step(0, 2'b00, 1, "R6");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule